// File: doc/BRIEF.md
# Dual-Plane Pixel Source Selector

This stage sits in a display scanout path and turns three co-located source words into one packed 32-bit color per accepted pixel. Each input beat carries an 8-bit palette index, a 32-bit direct-color word and a 32-bit control word for the same screen position. A tag byte in the control word chooses the source for that pixel alone. With one tag value the color is taken straight from the direct word. With any other value the index is looked up in a 256-entry color table. Palette and true-color pixels can therefore be mixed freely inside a frame.

The source stream always delivers full lines of `STRIDE` pixels (1024 by default). A runtime active-width input says how many pixels at the start of each line are visible. The stage counts accepted beats along the line and silently consumes the beats beyond that width.

The color table is a synchronous-read RAM that is loaded through a plain write port. The direct and tag information is delayed by one register so that both paths meet at the output multiplexer in the same cycle. A static mode input selects red-first or blue-first packing. Both edges use valid/ready handshakes, and the pipeline stalls cleanly under backpressure.

Top module: `dual_plane_pixel_sel`

## Requirements
- R1: A pixel whose control word has bits 31:24 equal to 8'h03 takes its color from the direct word. Every other value of that byte (for example 8'h00, 8'h02, 8'h04, 8'h13, 8'h83, 8'hFF) selects the palette path.
- R2: On the palette path the 8-bit index reads a table entry written through `palWe`/`palAddr`/`palData`, where `palData` holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R3: On the direct path, bits 31:24 of the direct word are ignored, bits 23:16 are blue, bits 15:8 are green and bits 7:0 are red.
- R4: With `bgrMode`=0 the output is {8'h00, red, green, blue}. With `bgrMode`=1 it is {8'h00, blue, green, red}.
- R5: Bits 31:24 of `outPixel` are zero whenever `outValid` is high.
- R6: A pixel accepted on a clock edge (`inValid` and `inReady` both high) whose column is below the active width appears with `outValid` high right after the next clock edge.
- R7: While `outValid` is high and `outReady` is low, `outPixel` and `outValid` hold and `inReady` is low, so no pixel is dropped or repeated.
- R8: Accepted beats are counted as columns 0..STRIDE-1, and the count wraps to 0 after STRIDE-1. A beat whose column is not less than `activeWidth` is consumed and never emitted. An `activeWidth` of 0 emits nothing.
- R9: After reset `outValid` is low, `inReady` is high and the next accepted beat is column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| activeWidth | input | 11 | Visible pixels per line, 0..STRIDE |
| bgrMode | input | 1 | Output packing: 0 red-first, 1 blue-first |
| palWe | input | 1 | Color table write enable |
| palAddr | input | 8 | Color table write address |
| palData | input | 24 | Color table entry {red, green, blue} |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Stage can accept a beat |
| inIndex | input | 8 | Indexed-plane value |
| inDirect | input | 32 | Direct-color plane word |
| inCtrl | input | 32 | Control plane word, tag in bits 31:24 |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Consumer accepts the pixel |
| outPixel | output | 32 | Packed output color |

## Verification
The in-RTL properties check several rules on every cycle: that a stalled output holds both its value and its valid, that the input is refused during a stall, that a visible accepted beat shows up one cycle later while a clipped one does not, that the direct path maps its bytes to the output in the selected order, and that the top byte stays zero. Other behaviour can only be shown by the bench's scenarios. These include the palette contents reaching the output for chosen indices, near-miss tag values that fall back to the palette, the exact number of pixels emitted per line for several widths across the column wrap, and the restart at column 0 after a reset. The bench also runs an end-to-end in-order comparison under irregular valid and ready patterns.

// File: rtl/pixsel_pkg.sv
package pixsel_pkg;
  // Tag value in control bits 31:24 that selects the direct-color path
  localparam logic [7:0] DIRECT_TAG = 8'h03;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic advance;  // stage register may load (not stalled)
    logic fire;     // an input beat is accepted this cycle
    logic keep;     // accepted beat lies inside the active width
  } pixsel_strobe_t;

  function automatic logic [23:0] packColor(input logic [7:0] red,
                                            input logic [7:0] grn,
                                            input logic [7:0] blu,
                                            input logic bgr);
    return bgr ? {blu, grn, red} : {red, grn, blu};
  endfunction
endpackage

// File: rtl/pixsel_ctrl.sv
module pixsel_ctrl
  import pixsel_pkg::*;
#(
  parameter int STRIDE = 1024,
  localparam int COL_W = $clog2(STRIDE),
  localparam int WID_W = $clog2(STRIDE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WID_W-1:0] activeWidth,
  input  logic             inValid,
  output logic             inReady,
  input  logic             outReady,
  output logic             outValid,
  output pixsel_strobe_t   strobe
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(STRIDE - 1);

  logic [COL_W-1:0] colQ;
  logic             stageValidQ;
  logic             advance;
  logic             fire;
  logic             keep;

  assign advance = !stageValidQ || outReady;
  assign fire    = inValid && advance;
  assign keep    = {1'b0, colQ} < activeWidth;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colQ        <= '0;
      stageValidQ <= 1'b0;
    end else begin
      if (fire) begin
        colQ <= (colQ == LAST_COL) ? '0 : colQ + 1'b1;
      end
      if (advance) begin
        stageValidQ <= fire && keep;
      end
    end
  end

  assign inReady        = advance;
  assign outValid       = stageValidQ;
  assign strobe.advance = advance;
  assign strobe.fire    = fire;
  assign strobe.keep    = keep;

  // R8
  clip_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && ({1'b0, colQ} >= activeWidth)) |=> !outValid);

  // R6
  accept_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && ({1'b0, colQ} < activeWidth)) |=> outValid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);
endmodule

// File: rtl/pixsel_datapath.sv
module pixsel_datapath
  import pixsel_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int PAL_DEPTH = 2 ** IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  pixsel_strobe_t   strobe,
  input  logic             bgrMode,
  input  logic             palWe,
  input  logic [IDX_W-1:0] palAddr,
  input  logic [23:0]      palData,
  input  logic [IDX_W-1:0] inIndex,
  input  logic [31:0]      inDirect,
  input  logic [31:0]      inCtrl,
  output logic [31:0]      outPixel
);
  logic [23:0] palMem [PAL_DEPTH];
  logic [23:0] palRdQ;
  logic        useDirectQ;
  logic [23:0] directQ;
  logic [23:0] palPacked;
  logic [23:0] dirPacked;

  // Color table: write port plus registered read that holds during a stall
  always_ff @(posedge clk) begin
    if (palWe) begin
      palMem[palAddr] <= palData;
    end
    if (strobe.advance) begin
      palRdQ <= palMem[inIndex];
    end
  end

  // Delay line for the direct path, aligned with the table read latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      useDirectQ <= 1'b0;
      directQ    <= '0;
    end else if (strobe.advance) begin
      useDirectQ <= (inCtrl[31:24] == DIRECT_TAG);
      directQ    <= inDirect[23:0];
    end
  end

  // Table entry is {red, green, blue}; direct word low lanes are {blue, green, red}
  assign palPacked = packColor(palRdQ[23:16], palRdQ[15:8], palRdQ[7:0], bgrMode);
  assign dirPacked = packColor(directQ[7:0], directQ[15:8], directQ[23:16], bgrMode);

  assign outPixel = {8'h00, useDirectQ ? dirPacked : palPacked};

  // R1 R3 R4
  dir_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.keep && inCtrl[31:24] == 8'h03 && $stable(bgrMode))
      |=> outPixel[23:0] == ($past(bgrMode)
            ? {$past(inDirect[23:16]), $past(inDirect[15:8]), $past(inDirect[7:0])}
            : {$past(inDirect[7:0]), $past(inDirect[15:8]), $past(inDirect[23:16])}));
endmodule

// File: rtl/dual_plane_pixel_sel.sv
module dual_plane_pixel_sel
  import pixsel_pkg::*;
#(
  parameter int STRIDE = 1024,
  parameter int IDX_W = 8,
  localparam int WID_W = $clog2(STRIDE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WID_W-1:0] activeWidth,
  input  logic             bgrMode,
  input  logic             palWe,
  input  logic [IDX_W-1:0] palAddr,
  input  logic [23:0]      palData,
  input  logic             inValid,
  output logic             inReady,
  input  logic [IDX_W-1:0] inIndex,
  input  logic [31:0]      inDirect,
  input  logic [31:0]      inCtrl,
  output logic             outValid,
  input  logic             outReady,
  output logic [31:0]      outPixel
);
  pixsel_strobe_t strobe;

  pixsel_ctrl #(.STRIDE(STRIDE)) uCtrl (
    .clk(clk), .rstN(rstN), .activeWidth(activeWidth),
    .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .strobe(strobe)
  );

  pixsel_datapath #(.IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bgrMode(bgrMode),
    .palWe(palWe), .palAddr(palAddr), .palData(palData),
    .inIndex(inIndex), .inDirect(inDirect), .inCtrl(inCtrl),
    .outPixel(outPixel)
  );

  // R7
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && $stable(bgrMode)) |=> $stable(outPixel));

  // R5
  top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outPixel[31:24] == 8'h00);
endmodule

// File: tb/tb_dual_plane_pixel_sel.sv
module tb_dual_plane_pixel_sel;
  localparam int STRIDE = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] activeWidth = 11'd1024;
  logic        bgrMode = 1'b0;
  logic        palWe = 1'b0;
  logic [7:0]  palAddr = '0;
  logic [23:0] palData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inIndex = '0;
  logic [31:0] inDirect = '0;
  logic [31:0] inCtrl = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outPixel;

  int errors = 0;
  int checks = 0;
  int benchCol = 0;
  int pixBase = 0;

  always #4 clk = ~clk;

  dual_plane_pixel_sel dut (
    .clk(clk), .rstN(rstN), .activeWidth(activeWidth), .bgrMode(bgrMode),
    .palWe(palWe), .palAddr(palAddr), .palData(palData),
    .inValid(inValid), .inReady(inReady), .inIndex(inIndex),
    .inDirect(inDirect), .inCtrl(inCtrl),
    .outValid(outValid), .outReady(outReady), .outPixel(outPixel)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] palEntry(input int i);
    return {8'(i), 8'(255 - i), 8'(i) ^ 8'h5a};
  endfunction

  function automatic logic [7:0] pickTag(input int k, input int kind);
    logic [7:0] misses [7] = '{8'h00, 8'h02, 8'h04, 8'h83, 8'h13, 8'h30, 8'hFF};
    if (kind == 1) return 8'h03;
    if (kind == 2 && (k % 2) == 0) return 8'h03;
    return misses[k % 7];
  endfunction

  function automatic logic [31:0] expPix(input logic [7:0] idx, input logic [31:0] dw,
                                         input logic [31:0] cw, input logic bgr);
    logic [7:0] r, g, b;
    if (cw[31:24] == 8'h03) begin
      r = dw[7:0]; g = dw[15:8]; b = dw[23:16];
    end else begin
      r = palEntry(int'(idx))[23:16]; g = palEntry(int'(idx))[15:8];
      b = palEntry(int'(idx))[7:0];
    end
    return bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
  endfunction

  task automatic driveBeat(input int k, input int kind);
    inIndex  = 8'(k * 37 + 11);
    inDirect = {8'(k * 13 + 9), 8'(k * 5 + 1), 8'(k * 29 + 7), 8'(k * 3 + 100)};
    inCtrl   = {pickTag(k, kind), 24'(k * 32'h1234)};
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    benchCol = 0;
  endtask

  task automatic loadPalette();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      palWe = 1'b1; palAddr = 8'(i); palData = palEntry(i);
    end
    @(negedge clk);
    palWe = 1'b0;
  endtask

  // Streams n beats; compares every emitted pixel in order with a queue
  task automatic runStream(input int n, input int kind, input int readyMode,
                           input int validMode, input string req);
    logic [31:0] expQ [$];
    logic [31:0] expV;
    int sent = 0;
    int got = 0;
    int wanted = 0;
    int cyc = 0;
    while ((sent < n || expQ.size() > 0) && cyc < 40000) begin
      @(negedge clk);
      inValid = (sent < n) && (validMode == 0 || (cyc % 4) != 1);
      driveBeat(pixBase + sent, kind);
      outReady = (readyMode == 0) || (((cyc * 7) % 5) < 3);
      #1;
      if (outValid && outReady) begin
        got++;
        if (expQ.size() == 0) check(1'b0, {req, " extra pixel"}, outPixel, 32'h0);
        else begin
          expV = expQ.pop_front();
          check(outPixel == expV, req, outPixel, expV);
        end
      end
      if (outValid && !outReady) check(!inReady, "R7 input blocked", 32'(inReady), 32'h0);
      if (inValid && inReady) begin
        if (benchCol < int'(activeWidth)) begin
          expQ.push_back(expPix(inIndex, inDirect, inCtrl, bgrMode));
          wanted++;
        end
        benchCol = (benchCol + 1) % STRIDE;
        sent++;
      end
      cyc++;
    end
    pixBase += n;
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b1;
    check(got == wanted && sent == n, {req, " count"}, 32'(got), 32'(wanted));
  endtask

  task automatic testReset();
    doReset();
    check(outValid == 1'b0, "R9 outValid after reset", 32'(outValid), 32'h0);
    check(inReady == 1'b1, "R9 inReady after reset", 32'(inReady), 32'h1);
  endtask

  task automatic testLatency();
    activeWidth = 11'd1024; bgrMode = 1'b0;
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b1; driveBeat(5, 1);
    @(negedge clk);
    inValid = 1'b0;
    benchCol = (benchCol + 1) % STRIDE;
    check(outValid == 1'b1, "R6 one-cycle latency", 32'(outValid), 32'h1);
    check(outPixel == expPix(8'(5 * 37 + 11), {8'(74), 8'(26), 8'(152), 8'(115)},
          32'h03000000, 1'b0), "R6 R3 latency pixel", outPixel, 32'h0);
    @(negedge clk);
    check(outValid == 1'b0, "R6 single pixel only", 32'(outValid), 32'h0);
  endtask

  task automatic testClipAfterReset();
    doReset();
    activeWidth = 11'd1;
    @(negedge clk);
    inValid = 1'b1; driveBeat(0, 1);
    @(negedge clk);
    check(outValid == 1'b1, "R9 R8 column 0 emitted", 32'(outValid), 32'h1);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b0, "R8 column 1 clipped", 32'(outValid), 32'h0);
    benchCol = 2;
  endtask

  initial begin
    testReset();
    loadPalette();
    testLatency();
    activeWidth = 11'd1024; bgrMode = 1'b0;
    runStream(96, 0, 0, 0, "R2 R4 palette rgb");
    runStream(64, 1, 0, 0, "R3 R5 direct rgb");
    bgrMode = 1'b1;
    runStream(96, 2, 0, 0, "R1 R4 mixed bgr");
    runStream(200, 2, 1, 1, "R7 backpressure");
    bgrMode = 1'b0;
    testClipAfterReset();
    activeWidth = 11'd37;
    runStream(2100, 2, 0, 1, "R8 width 37 wrap");
    activeWidth = 11'd0;
    runStream(300, 0, 1, 0, "R8 width zero");
    activeWidth = 11'd1024;
    runStream(120, 2, 1, 1, "R1 R7 full width");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule